// File: doc/BRIEF.md
# Exact Algebraic-Integer 8-Point DCT Row Engine

This block computes an 8-point one-dimensional DCT, following the Arai fast flow, without ever leaving an exact integer domain. Each number on the datapath is a four-integer tuple over the basis {1, z1, z2, z1·z2}, where z1 = sqrt(2+sqrt2) + sqrt(2-sqrt2) and z2 = sqrt(2+sqrt2) - sqrt(2-sqrt2). Integer samples enter as tuples whose only non-zero part is the integer part. The five cosine products of the flow become wired shifts, negations and additions of tuple components. This holds because every cosine constant, scaled by four, has an exact tuple made of small entries (0, ±1, ±2).

A row of eight signed samples is accepted on every clock. Eight coefficient tuples leave a fixed four cycles later. The tuples are wide enough that no stage can overflow. To keep one common scale, the branches that carry no cosine product are shifted left by two. As a result, every output is exactly four times the unnormalised Arai output. A later stage removes that factor and maps the tuples to fixed point. The transposition that a 2-D transform needs is handled elsewhere.

Top module: `dct_ai8`

## Requirements
- R1: Coefficient k is `coef_o[k]`, and its component index c holds, in order c=0..3, the weights of 1, z1, z2 and z1·z2. An impulse of 1 on sample 0 yields tuple (4,0,0,1) at k=2 and (4,1,1,0) at k=1.
- R2: For any row, the tuple at k decodes as a0 + a1·z1 + a2·z2 + a3·z1·z2. The decoded value equals four times the k-th output of the Arai flow applied to that row, with no rounding anywhere.
- R3: Coefficients 0 and 4 are pure integers. Components 1..3 are zero. Component 0 is 4·(sum of the samples) for k=0 and 4·(x0−x1−x2+x3+x4−x5−x6+x7) for k=4.
- R4: `valid_o` repeats `valid_i` exactly four clocks later. The coefficients of a row are presented in the cycle where its `valid_o` is high.
- R5: Rows presented on consecutive clocks each produce correct coefficients on consecutive clocks.
- R6: Full-scale rows (all minimum, or alternating maximum and minimum) give exact results at both supported sample widths, L=4 and L=8. No overflow occurs.
- R7: While `rst_ni` is low, `valid_o` is 0 and every coefficient component is 0.
- R8: A row whose eight samples are equal produces all-zero tuples for coefficients 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Row on `row_i` is valid |
| row_i | input | 8×L | Eight signed samples, element k is sample k |
| valid_o | output | 1 | Coefficients on `coef_o` are valid |
| coef_o | output | 8×4×(L+8) | Eight signed four-component coefficient tuples |

## Verification
The bench builds two copies of the block side by side: one with L=8 and one with L=4. Rows that fit in four bits are driven into both copies, so each pattern is checked at both widths. The copies differ in the extremes they reach. Only the narrow copy can saturate its input range at -8 and 7, and only the wide copy can reach -128 and 127. This exercises the growth margins at both sizes. The bench decodes each output tuple in double precision and compares it with a floating-point Arai flow. It also checks exact tuples for an impulse and for flat rows.

// File: rtl/dct_ai_pkg.sv
package dct_ai_pkg;
  // Cosine constants of the Arai flow, each scaled by four
  typedef enum logic [1:0] {
    K_C4   = 2'd0,
    K_C6   = 2'd1,
    K_C2M6 = 2'd2,
    K_C2P6 = 2'd3
  } ai_const_e;

  localparam int unsigned NPT   = 8;
  localparam int unsigned NCOMP = 4;
  localparam int unsigned LAT   = 4;
  localparam int unsigned GUARD = 8;
endpackage

// File: rtl/dct_pre_bfly.sv
module dct_pre_bfly #(
  parameter int L = 8,
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0][L-1:0]   row_i,
  output logic [3:0][W-1:0]   sum_o,
  output logic [3:0][W-1:0]   dif_o
);
  for (genvar k = 0; k < 4; k++) begin : g_pair
    logic signed [W-1:0] xa, xb;
    assign xa = {{(W-L){row_i[k][L-1]}}, row_i[k]};
    assign xb = {{(W-L){row_i[7-k][L-1]}}, row_i[7-k]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o[k] <= '0;
        dif_o[k] <= '0;
      end else begin
        sum_o[k] <= xa + xb;
        dif_o[k] <= xa - xb;
      end
    end
  end
endmodule

// File: rtl/ai_cmul.sv
// Tuple times scaled cosine, using z1*z1z2 = 2z1+2z2, z2*z1z2 = 2z1-2z2, (z1z2)^2 = 8
module ai_cmul
  import dct_ai_pkg::*;
#(
  parameter int        W = 16,
  parameter ai_const_e K = K_C4
) (
  input  logic [3:0][W-1:0] a_i,
  output logic [3:0][W-1:0] p_o
);
  logic signed [W-1:0] a00, a10, a01, a11;
  assign a00 = a_i[0];
  assign a10 = a_i[1];
  assign a01 = a_i[2];
  assign a11 = a_i[3];

  if (K == K_C4) begin : g_c4
    assign p_o[0] = a11 <<< 3;
    assign p_o[1] = (a10 + a01) <<< 1;
    assign p_o[2] = (a10 - a01) <<< 1;
    assign p_o[3] = a00;
  end else if (K == K_C6) begin : g_c6
    assign p_o[0] = (a10 - a01) <<< 2;
    assign p_o[1] = a00;
    assign p_o[2] = (a11 <<< 2) - a00;
    assign p_o[3] = a01 <<< 1;
  end else if (K == K_C2M6) begin : g_c2m6
    assign p_o[0] = a01 <<< 3;
    assign p_o[1] = a11 <<< 2;
    assign p_o[2] = (a00 <<< 1) - (a11 <<< 2);
    assign p_o[3] = (a10 - a01) <<< 1;
  end else begin : g_c2p6
    assign p_o[0] = a10 <<< 3;
    assign p_o[1] = (a00 <<< 1) + (a11 <<< 2);
    assign p_o[2] = a11 <<< 2;
    assign p_o[3] = (a10 + a01) <<< 1;
  end
endmodule

// File: rtl/dct_ai8.sv
module dct_ai8
  import dct_ai_pkg::*;
#(
  parameter  int L = 8,
  localparam int W = L + GUARD
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [7:0][L-1:0]      row_i,
  output logic                   valid_o,
  output logic [7:0][3:0][W-1:0] coef_o
);
  typedef logic [3:0][W-1:0] tup_t;

  function automatic tup_t lift(input logic [W-1:0] v);
    tup_t t = '0;
    t[0] = v;
    return t;
  endfunction

  function automatic tup_t tadd(input tup_t a, input tup_t b);
    tup_t t;
    for (int c = 0; c < NCOMP; c++) t[c] = a[c] + b[c];
    return t;
  endfunction

  function automatic tup_t tsub(input tup_t a, input tup_t b);
    tup_t t;
    for (int c = 0; c < NCOMP; c++) t[c] = a[c] - b[c];
    return t;
  endfunction

  // stage 1: input butterflies
  logic [3:0][W-1:0] s1_sum, s1_dif;
  dct_pre_bfly #(.L(L), .W(W)) i_bfly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .row_i (row_i),
    .sum_o (s1_sum),
    .dif_o (s1_dif)
  );

  // stage 2: even and odd sums
  logic signed [W-1:0] e10, e11, e12, e13, o10, o11, o12, o7;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {e10, e11, e12, e13} <= '0;
      {o10, o11, o12, o7}  <= '0;
    end else begin
      e10 <= s1_sum[0] + s1_sum[3];
      e13 <= s1_sum[0] - s1_sum[3];
      e11 <= s1_sum[1] + s1_sum[2];
      e12 <= s1_sum[1] - s1_sum[2];
      o10 <= s1_dif[3] + s1_dif[2];
      o11 <= s1_dif[2] + s1_dif[1];
      o12 <= s1_dif[1] + s1_dif[0];
      o7  <= s1_dif[0];
    end
  end

  // stage 3: the five constant products
  logic [W-1:0] e_mix, o_mix;
  assign e_mix = e12 + e13;
  assign o_mix = o10 - o12;

  tup_t p1_c, p2_c, p3_c, p4_c, p5_c;
  ai_cmul #(.W(W), .K(K_C4))   i_mul_e  (.a_i(lift(e_mix)), .p_o(p1_c));
  ai_cmul #(.W(W), .K(K_C2M6)) i_mul_lo (.a_i(lift(o10)),   .p_o(p2_c));
  ai_cmul #(.W(W), .K(K_C4))   i_mul_mi (.a_i(lift(o11)),   .p_o(p3_c));
  ai_cmul #(.W(W), .K(K_C2P6)) i_mul_hi (.a_i(lift(o12)),   .p_o(p4_c));
  ai_cmul #(.W(W), .K(K_C6))   i_mul_sh (.a_i(lift(o_mix)), .p_o(p5_c));

  logic signed [W-1:0] y0_q, y4_q, e13_q, o7_q;
  tup_t p1_q, p2_q, p3_q, p4_q, p5_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {y0_q, y4_q, e13_q, o7_q} <= '0;
      {p1_q, p2_q, p3_q, p4_q, p5_q} <= '0;
    end else begin
      // branches without a constant take the same x4 scale
      y0_q  <= (e10 + e11) <<< 2;
      y4_q  <= (e10 - e11) <<< 2;
      e13_q <= e13 <<< 2;
      o7_q  <= o7 <<< 2;
      p1_q  <= p1_c;
      p2_q  <= p2_c;
      p3_q  <= p3_c;
      p4_q  <= p4_c;
      p5_q  <= p5_c;
    end
  end

  // stage 4: output recombination
  tup_t zl_c, zh_c, za_c, zb_c;
  tup_t [7:0] y_c;
  always_comb begin
    zl_c   = tadd(p2_q, p5_q);
    zh_c   = tadd(p4_q, p5_q);
    za_c   = tadd(lift(o7_q), p3_q);
    zb_c   = tsub(lift(o7_q), p3_q);
    y_c[0] = lift(y0_q);
    y_c[4] = lift(y4_q);
    y_c[2] = tadd(lift(e13_q), p1_q);
    y_c[6] = tsub(lift(e13_q), p1_q);
    y_c[5] = tadd(zb_c, zl_c);
    y_c[3] = tsub(zb_c, zl_c);
    y_c[1] = tadd(za_c, zh_c);
    y_c[7] = tsub(za_c, zh_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_o <= '0;
    else         coef_o <= y_c;
  end

  logic [LAT-1:0] vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end
  assign valid_o = vld_q[LAT-1];
endmodule

// File: rtl/dct_ai8_chk.sv
module dct_ai8_chk
  import dct_ai_pkg::*;
#(
  parameter  int L = 8,
  localparam int W = L + GUARD
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [7:0][L-1:0]      row_i,
  input logic                   valid_o,
  input logic [7:0][3:0][W-1:0] coef_o
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic signed [W-1:0] dc4, ac4;
  logic                flat;
  always_comb begin
    logic signed [W-1:0] s, a;
    s = '0;
    a = '0;
    flat = 1'b1;
    for (int k = 0; k < NPT; k++) begin
      s = s + W'($signed(row_i[k]));
      if (k == 0 || k == 3 || k == 4 || k == 7) a = a + W'($signed(row_i[k]));
      else                                      a = a - W'($signed(row_i[k]));
      if (row_i[k] != row_i[0]) flat = 1'b0;
    end
    dc4 = s <<< 2;
    ac4 = a <<< 2;
  end

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  assert_dc_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && $past(valid_i, 4)) |-> (coef_o[0][0] == $past(dc4, 4)));

  assert_pure_int_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && $past(valid_i, 4)) |->
      (coef_o[0][3:1] == '0 && coef_o[4][3:1] == '0 && coef_o[4][0] == $past(ac4, 4)));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(coef_o[0][0]) <= $signed(W'(1) <<< (L + 4)) &&
                 $signed(coef_o[0][0]) >= -$signed(W'(1) <<< (L + 4))));

  assert_flat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && $past(valid_i, 4) && $past(flat, 4)) |-> (coef_o[7:1] == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R7: assert (!valid_o && coef_o == '0);
    end
  end
endmodule

bind dct_ai8 dct_ai8_chk #(.L(L)) i_dct_ai8_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .row_i  (row_i),
  .valid_o(valid_o),
  .coef_o (coef_o)
);

// File: tb/test_dct_ai8.sv
module test_dct_ai8;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int LN = 4;
  localparam int WW = LW + 8;
  localparam int WN = LN + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [7:0][LW-1:0] row_w = '0;
  logic [7:0][LN-1:0] row_n = '0;
  logic vout_w, vout_n;
  logic [7:0][3:0][WW-1:0] coef_w;
  logic [7:0][3:0][WN-1:0] coef_n;

  int n_checks = 0;
  int n_errors = 0;
  real zr1, zr2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct_ai8 #(.L(LW)) i_dct_ai8 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .row_i(row_w),
    .valid_o(vout_w), .coef_o(coef_w));

  dct_ai8 #(.L(LN)) i_dct_ai8_narrow (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .row_i(row_n),
    .valid_o(vout_n), .coef_o(coef_n));

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  function automatic void arai_ref(input int x[8], output real y[8]);
    real c4, c6, c2m6, c2p6;
    real t0, t1, t2, t3, t4, t5, t6, t7, a10, a11, a12, a13, m, q5, q2, q4, q3, u11, u13;
    c4 = $cos(3.14159265358979323846 / 4.0);
    c6 = $cos(3.0 * 3.14159265358979323846 / 8.0);
    c2m6 = $cos(3.14159265358979323846 / 8.0) - c6;
    c2p6 = $cos(3.14159265358979323846 / 8.0) + c6;
    t0 = x[0] + x[7]; t7 = x[0] - x[7];
    t1 = x[1] + x[6]; t6 = x[1] - x[6];
    t2 = x[2] + x[5]; t5 = x[2] - x[5];
    t3 = x[3] + x[4]; t4 = x[3] - x[4];
    a10 = t0 + t3; a13 = t0 - t3; a11 = t1 + t2; a12 = t1 - t2;
    y[0] = a10 + a11; y[4] = a10 - a11;
    m = (a12 + a13) * c4;
    y[2] = a13 + m; y[6] = a13 - m;
    a10 = t4 + t5; a11 = t5 + t6; a12 = t6 + t7;
    q5 = (a10 - a12) * c6;
    q2 = c2m6 * a10 + q5;
    q4 = c2p6 * a12 + q5;
    q3 = a11 * c4;
    u11 = t7 + q3; u13 = t7 - q3;
    y[5] = u13 + q2; y[3] = u13 - q2;
    y[1] = u11 + q4; y[7] = u11 - q4;
  endfunction

  function automatic void grab(input bit nar, output int t[8][4]);
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 4; c++)
        t[k][c] = nar ? int'($signed(coef_n[k][c])) : int'($signed(coef_w[k][c]));
  endfunction

  // R2: decode each tuple and compare with 4x the float flow
  task automatic check_row(input bit nar, input int x[8], input string req);
    int t[8][4];
    real y[8];
    real dec, err;
    grab(nar, t);
    arai_ref(x, y);
    check((nar ? vout_n : vout_w) == 1'b1, req, "valid_o", nar ? vout_n : vout_w, 1);
    for (int k = 0; k < 8; k++) begin
      dec = t[k][0] + t[k][1] * zr1 + t[k][2] * zr2 + t[k][3] * zr1 * zr2;
      err = dec - 4.0 * y[k];
      if (err < 0.0) err = -err;
      check(err < 1e-6, req, $sformatf("%s coef %0d", nar ? "L4" : "L8", k), dec, 4.0 * y[k]);
    end
    // R3: integer-only coefficients
    for (int c = 1; c < 4; c++) begin
      check(t[0][c] == 0, "R3", $sformatf("k0 comp %0d", c), t[0][c], 0);
      check(t[4][c] == 0, "R3", $sformatf("k4 comp %0d", c), t[4][c], 0);
    end
  endtask

  task automatic drive(input int x[8], input bit v);
    for (int k = 0; k < 8; k++) begin
      row_w[k] = x[k][LW-1:0];
      row_n[k] = x[k][LN-1:0];
    end
    vin = v;
  endtask

  function automatic bit fits_narrow(input int x[8]);
    for (int k = 0; k < 8; k++) if (x[k] < -8 || x[k] > 7) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(vout_w == 1'b0 && vout_n == 1'b0, "R7", "valid_o in reset", vout_w, 0);
    check(coef_w == '0 && coef_n == '0, "R7", "coef_o in reset", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_single(input int x[8], input string req);
    int zero[8] = '{default: 0};
    @(negedge clk);
    drive(x, 1'b1);
    @(negedge clk);
    drive(zero, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check(vout_w == 1'b0, "R4", "valid_o one cycle early", vout_w, 0);
    @(negedge clk);
    check_row(1'b0, x, req);
    if (fits_narrow(x)) check_row(1'b1, x, req);
  endtask

  task automatic t_impulse();
    int x[8] = '{1, 0, 0, 0, 0, 0, 0, 0};
    int t[8][4];
    t_single(x, "R2");
    grab(1'b0, t);
    // R1: with z1*z1z2 = 2z1+2z2 the impulse gives exact small tuples
    check(t[2][0] == 4 && t[2][1] == 0 && t[2][2] == 0 && t[2][3] == 1, "R1", "k2 tuple a3", t[2][3], 1);
    check(t[1][0] == 4 && t[1][1] == 1 && t[1][2] == 1 && t[1][3] == 0, "R1", "k1 tuple a1", t[1][1], 1);
  endtask

  task automatic t_flat(input int v);
    int x[8];
    int t[8][4];
    for (int k = 0; k < 8; k++) x[k] = v;
    t_single(x, "R8");
    grab(1'b0, t);
    for (int k = 1; k < 8; k++)
      for (int c = 0; c < 4; c++)
        check(t[k][c] == 0, "R8", $sformatf("flat k%0d c%0d", k, c), t[k][c], 0);
    check(t[0][0] == 32 * v, "R3", "flat dc", t[0][0], 32 * v);
  endtask

  task automatic t_extreme();
    int lo_w[8] = '{default: -128};
    int alt_w[8] = '{127, -128, 127, -128, 127, -128, 127, -128};
    int lo_n[8] = '{default: -8};
    int alt_n[8] = '{-8, 7, 7, -8, 7, -8, -8, 7};
    t_single(lo_w, "R6");
    t_single(alt_w, "R6");
    t_single(lo_n, "R6");
    t_single(alt_n, "R6");
  endtask

  task automatic t_stream();
    int rows[8][8];
    int cur[8];
    int zero[8] = '{default: 0};
    logic [31:0] seed = 32'h1234_5678;
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 8; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        rows[i][k] = int'(seed[23:16]) - 128;
      end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        cur = rows[i-4];
        check_row(1'b0, cur, "R5");
      end
      if (i < 8) begin
        cur = rows[i];
        drive(cur, 1'b1);
      end else drive(zero, 1'b0);
    end
    @(negedge clk);
    check(vout_w == 1'b0, "R4", "valid_o after stream", vout_w, 0);
  endtask

  task automatic t_bubble();
    int x[8] = '{3, -2, 5, 1, -7, 4, 0, 6};
    @(negedge clk);
    drive(x, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(vout_w == 1'b0 && vout_n == 1'b0, "R4", "valid_o for idle row", vout_w, 0);
    end
    t_single(x, "R2");
  endtask

  initial begin
    zr1 = $sqrt(2.0 + $sqrt(2.0)) + $sqrt(2.0 - $sqrt(2.0));
    zr2 = $sqrt(2.0 + $sqrt(2.0)) - $sqrt(2.0 - $sqrt(2.0));
    t_reset();
    t_impulse();
    t_flat(-5);
    t_flat(100);
    t_bubble();
    t_extreme();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule